// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block picks, for every CPU, the most urgent interrupt that may be signalled to that CPU. It then drives that CPU's normal (IRQ) and fast (FIQ) request lines. Each interrupt is described by a set of inputs: enable, pending, active and group bits, an 8-bit priority and a bitmap of target CPUs. Each CPU supplies an interface control word, a priority mask and a running priority. A global control word enables the two interrupt groups for the whole distributor.

A pulse on the recompute input starts a scan. The scan walks the interrupt IDs from 0 upwards, one per clock, and every CPU's search runs in parallel during the same walk. When the last ID has been examined, the current-pending ID and both request lines of every CPU are updated together, and a one-cycle done pulse is raised. A recompute pulse that arrives during a scan restarts it from ID 0. A scan only looks at the inputs as they are during that scan. Controls and masks are taken in its final cycle, so the environment holds them steady while a scan is running.

Top module: `irq_prio_select`

## Requirements
- R1: After reset, every current-pending ID is 1023, which means "no interrupt". All IRQ and FIQ lines are low and done is low.
- R2: A recompute pulse sampled at clock edge k raises done for exactly one cycle after edge k+NUM_IRQ. A recompute pulse during a scan restarts the scan from ID 0.
- R3: An interrupt is a candidate for a CPU only if it is enabled, pending and not active. It must also have an ID below 32, or have that CPU's bit set in its target bitmap (bit `id*NUM_CPU+cpu` of the target input).
- R4: Among the candidates, the numerically lowest priority wins. When priorities are equal, the lowest ID wins.
- R5: With no candidate, the current-pending ID is 1023 and both lines are low.
- R6: If neither group is enabled in the distributor control, or neither is enabled in the CPU control, that CPU's ID is 1023 and both lines are low. Group 0 is enabled by bit 0 and group 1 by bit 1 of each control word.
- R7: The winner is published as the current-pending ID only when its priority is strictly below the CPU's 8-bit priority mask. Otherwise the ID is 1023 and the lines are low.
- R8: A request line is raised only when the winner's priority is also strictly below the CPU's 9-bit running priority. A running priority of 0x100 means idle.
- R9: A request line is raised only when the winner's group is enabled both in the distributor control and in the CPU control.
- R10: A signalled group-0 winner raises FIQ when bit 2 of the CPU control word is set. Every other signalled winner raises IRQ. IRQ and FIQ are never high together for one CPU.
- R11: The IDs and lines change only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recompute_i | input | 1 | Start or restart a scan |
| int_enable_i | input | NUM_IRQ | Per-interrupt enable |
| int_pending_i | input | NUM_IRQ | Per-interrupt pending |
| int_active_i | input | NUM_IRQ | Per-interrupt active |
| int_group_i | input | NUM_IRQ | Per-interrupt group (0 or 1) |
| int_prio_i | input | NUM_IRQ*8 | Priority of interrupt n at bits [8n+7:8n] |
| int_target_i | input | NUM_IRQ*NUM_CPU | Target bitmap of interrupt n at bits [n*NUM_CPU +: NUM_CPU] |
| dist_ctrl_i | input | 2 | Distributor group enables {grp1, grp0} |
| cpu_ctrl_i | input | NUM_CPU*3 | Per CPU {fiq_en, grp1_en, grp0_en} |
| prio_mask_i | input | NUM_CPU*8 | Per-CPU priority mask |
| run_prio_i | input | NUM_CPU*9 | Per-CPU running priority |
| cur_id_o | output | NUM_CPU*10 | Per-CPU current-pending ID |
| irq_o | output | NUM_CPU | Per-CPU IRQ line |
| fiq_o | output | NUM_CPU | Per-CPU FIQ line |
| done_o | output | 1 | One-cycle scan-complete pulse |

## Verification
The bench builds the block with two CPUs and 64 interrupts. The two CPUs make it possible to drive each CPU with different masks, running priorities and control words in the same scan, and to compare the results side by side. The 64 interrupts reach past the 32 CPU-internal IDs, so the target bitmap decides whether an upper ID counts for a given CPU. They also keep every full scan short enough to count its length exactly, including a restart from the middle of a scan.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int unsigned ID_W        = 10;
  localparam int unsigned PRIO_W      = 8;
  localparam int unsigned EXT_PRIO_W  = PRIO_W + 1;
  localparam int unsigned INTERNAL_IDS = 32;
  localparam int unsigned CTRL_W      = 3;

  typedef logic [ID_W-1:0]       irq_id_t;
  typedef logic [EXT_PRIO_W-1:0] ext_prio_t;

  localparam irq_id_t   NO_IRQ    = irq_id_t'(1023);
  localparam ext_prio_t IDLE_PRIO = ext_prio_t'(9'h100);

  localparam int unsigned CTRL_GRP0 = 0;
  localparam int unsigned CTRL_GRP1 = 1;
  localparam int unsigned CTRL_FIQ  = 2;
endpackage

// File: rtl/irq_scan_ctrl.sv
module irq_scan_ctrl #(
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          recompute_i,
  output logic [IW-1:0] idx_o,
  output logic          step_o,
  output logic          first_o,
  output logic          last_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_IRQ - 1);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (recompute_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign idx_o   = idx_q;
  assign step_o  = busy_q & ~recompute_i;
  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == LAST_IDX);
  assign done_o  = done_q;
endmodule

// File: rtl/irq_best_track.sv
module irq_best_track
  import irq_sel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                first_i,
  input  logic                elig_i,
  input  irq_id_t             cand_id_i,
  input  logic [PRIO_W-1:0]   cand_prio_i,
  input  logic                cand_grp_i,
  output irq_id_t             best_id_o,
  output ext_prio_t           best_prio_o,
  output logic                best_grp_o
);
  irq_id_t   id_q, id_d, base_id;
  ext_prio_t prio_q, prio_d, base_prio;
  logic      grp_q, grp_d, base_grp, take;

  always_comb begin
    base_id   = first_i ? NO_IRQ    : id_q;
    base_prio = first_i ? IDLE_PRIO : prio_q;
    base_grp  = first_i ? 1'b0      : grp_q;
    take      = elig_i && ({1'b0, cand_prio_i} < base_prio);
    id_d      = take ? cand_id_i             : base_id;
    prio_d    = take ? {1'b0, cand_prio_i}   : base_prio;
    grp_d     = take ? cand_grp_i            : base_grp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= NO_IRQ;
      prio_q <= IDLE_PRIO;
      grp_q  <= 1'b0;
    end else if (step_i) begin
      id_q   <= id_d;
      prio_q <= prio_d;
      grp_q  <= grp_d;
    end
  end

  // Value as it stands after the current step; used at commit.
  assign best_id_o   = id_d;
  assign best_prio_o = prio_d;
  assign best_grp_o  = grp_d;
endmodule

// File: rtl/irq_line_gate.sv
module irq_line_gate
  import irq_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  irq_id_t           best_id_i,
  input  ext_prio_t         best_prio_i,
  input  logic              best_grp_i,
  input  logic [1:0]        dist_ctrl_i,
  input  logic [CTRL_W-1:0] cpu_ctrl_i,
  input  logic [PRIO_W-1:0] prio_mask_i,
  input  ext_prio_t         run_prio_i,
  output irq_id_t           cur_id_o,
  output logic              irq_o,
  output logic              fiq_o
);
  irq_id_t id_q, id_d;
  logic    irq_q, irq_d, fiq_q, fiq_d;
  logic    any_en, grp_en;

  always_comb begin
    any_en = (|dist_ctrl_i) && (|cpu_ctrl_i[CTRL_GRP1:CTRL_GRP0]);
    grp_en = dist_ctrl_i[best_grp_i] && cpu_ctrl_i[best_grp_i];
    id_d   = NO_IRQ;
    irq_d  = 1'b0;
    fiq_d  = 1'b0;
    if (any_en && (best_prio_i < {1'b0, prio_mask_i})) begin
      id_d = best_id_i;
      if ((best_prio_i < run_prio_i) && grp_en) begin
        if (!best_grp_i && cpu_ctrl_i[CTRL_FIQ]) fiq_d = 1'b1;
        else                                      irq_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= NO_IRQ;
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else if (commit_i) begin
      id_q  <= id_d;
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  assign cur_id_o = id_q;
  assign irq_o    = irq_q;
  assign fiq_o    = fiq_q;
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_sel_pkg::*;
#(
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          recompute_i,
  input  logic [NUM_IRQ-1:0]            int_enable_i,
  input  logic [NUM_IRQ-1:0]            int_pending_i,
  input  logic [NUM_IRQ-1:0]            int_active_i,
  input  logic [NUM_IRQ-1:0]            int_group_i,
  input  logic [NUM_IRQ*PRIO_W-1:0]     int_prio_i,
  input  logic [NUM_IRQ*NUM_CPU-1:0]    int_target_i,
  input  logic [1:0]                    dist_ctrl_i,
  input  logic [NUM_CPU*CTRL_W-1:0]     cpu_ctrl_i,
  input  logic [NUM_CPU*PRIO_W-1:0]     prio_mask_i,
  input  logic [NUM_CPU*EXT_PRIO_W-1:0] run_prio_i,
  output logic [NUM_CPU*ID_W-1:0]       cur_id_o,
  output logic [NUM_CPU-1:0]            irq_o,
  output logic [NUM_CPU-1:0]            fiq_o,
  output logic                          done_o
);
  localparam int unsigned IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [IW-1:0]        idx;
  logic                 step, first, last;
  logic                 base_ok, internal;
  logic [PRIO_W-1:0]    sel_prio;
  logic [NUM_CPU-1:0]   sel_target;
  irq_id_t              sel_id;

  irq_scan_ctrl #(.NUM_IRQ(NUM_IRQ)) i_scan (
    .clk(clk), .rst_n(rst_n), .recompute_i(recompute_i),
    .idx_o(idx), .step_o(step), .first_o(first), .last_o(last),
    .done_o(done_o)
  );

  always_comb begin
    base_ok    = int_enable_i[idx] & int_pending_i[idx] & ~int_active_i[idx];
    internal   = (32'(idx) < INTERNAL_IDS);
    sel_prio   = int_prio_i[idx*PRIO_W +: PRIO_W];
    sel_target = int_target_i[idx*NUM_CPU +: NUM_CPU];
    sel_id     = irq_id_t'(idx);
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_id_t   b_id;
    ext_prio_t b_prio;
    logic      b_grp;

    irq_best_track i_track (
      .clk(clk), .rst_n(rst_n), .step_i(step), .first_i(first),
      .elig_i(base_ok & (internal | sel_target[c])),
      .cand_id_i(sel_id), .cand_prio_i(sel_prio),
      .cand_grp_i(int_group_i[idx]),
      .best_id_o(b_id), .best_prio_o(b_prio), .best_grp_o(b_grp)
    );

    irq_line_gate i_gate (
      .clk(clk), .rst_n(rst_n), .commit_i(step & last),
      .best_id_i(b_id), .best_prio_i(b_prio), .best_grp_i(b_grp),
      .dist_ctrl_i(dist_ctrl_i),
      .cpu_ctrl_i(cpu_ctrl_i[c*CTRL_W +: CTRL_W]),
      .prio_mask_i(prio_mask_i[c*PRIO_W +: PRIO_W]),
      .run_prio_i(run_prio_i[c*EXT_PRIO_W +: EXT_PRIO_W]),
      .cur_id_o(cur_id_o[c*ID_W +: ID_W]),
      .irq_o(irq_o[c]), .fiq_o(fiq_o[c])
    );
  end
endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk
  import irq_sel_pkg::*;
#(
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned NUM_IRQ = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                dist_ctrl_i,
  input logic [NUM_CPU*ID_W-1:0]   cur_id_o,
  input logic [NUM_CPU-1:0]        irq_o,
  input logic [NUM_CPU-1:0]        fiq_o,
  input logic                      done_o
);
  assert_one_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & fiq_o) == '0);

  assert_hold_between_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(cur_id_o) && $stable(irq_o) && $stable(fiq_o)));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_dist_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(dist_ctrl_i) == 2'b00) |-> (irq_o == '0 && fiq_o == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    assert_line_has_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[c] || fiq_o[c]) |-> (cur_id_o[c*ID_W +: ID_W] != NO_IRQ));
  end
endmodule

bind irq_prio_select irq_prio_select_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) i_chk (
  .clk(clk), .rst_n(rst_n), .dist_ctrl_i(dist_ctrl_i), .cur_id_o(cur_id_o),
  .irq_o(irq_o), .fiq_o(fiq_o), .done_o(done_o)
);

// File: tb/test_irq_prio_select.sv
module test_irq_prio_select;
  localparam int NC = 2;
  localparam int NI = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recompute;
  logic [NI-1:0] en, pend, act, grp;
  logic [NI*8-1:0] prio;
  logic [NI*NC-1:0] tgt;
  logic [1:0] dctl;
  logic [NC*3-1:0] cctl;
  logic [NC*8-1:0] pmask;
  logic [NC*9-1:0] rprio;
  logic [NC*10-1:0] cur_id;
  logic [NC-1:0] irq, fiq;
  logic done;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_prio_select #(.NUM_CPU(NC), .NUM_IRQ(NI)) i_irq_prio_select (
    .clk(clk), .rst_n(rst_n), .recompute_i(recompute),
    .int_enable_i(en), .int_pending_i(pend), .int_active_i(act),
    .int_group_i(grp), .int_prio_i(prio), .int_target_i(tgt),
    .dist_ctrl_i(dctl), .cpu_ctrl_i(cctl), .prio_mask_i(pmask),
    .run_prio_i(rprio), .cur_id_o(cur_id), .irq_o(irq), .fiq_o(fiq),
    .done_o(done)
  );

  task automatic check(string req, int actual, int expected);
    total++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic check_cpu(string req, int c, int id, int i, int f);
    check(req, int'(cur_id[c*10 +: 10]), id);
    check(req, int'(irq[c]), i);
    check(req, int'(fiq[c]), f);
  endtask

  task automatic clear_all();
    en = '0; pend = '0; act = '0; grp = '0; prio = '0; tgt = '0;
    dctl = 2'b11; cctl = {3'b011, 3'b011};
    pmask = {8'hff, 8'hff}; rprio = {9'h100, 9'h100};
  endtask

  task automatic set_irq(int id, bit g, int p, bit [NC-1:0] t);
    en[id] = 1'b1; pend[id] = 1'b1; grp[id] = g;
    prio[id*8 +: 8] = 8'(p); tgt[id*NC +: NC] = t;
  endtask

  // Pulses recompute and returns the number of edges up to visible done.
  task automatic scan(output int edges);
    recompute = 1'b1;
    @(negedge clk);
    recompute = 1'b0;
    edges = 1;
    while (!done && edges < 500) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic t_reset();
    for (int c = 0; c < NC; c++) check_cpu("R1", c, 1023, 0, 0);
    check("R1", int'(done), 0);
  endtask

  task automatic t_timing_empty();
    int e;
    clear_all();
    scan(e);
    check("R2 scan length", e, NI + 1);
    @(negedge clk);
    check("R2 done one cycle", int'(done), 0);
    for (int c = 0; c < NC; c++) check_cpu("R5", c, 1023, 0, 0);
  endtask

  task automatic t_eligibility();
    int e;
    clear_all();
    set_irq(40, 1, 8'h20, 2'b10);
    set_irq(5, 1, 8'h40, 2'b00);
    set_irq(50, 1, 8'h00, 2'b11); act[50] = 1'b1;
    set_irq(45, 1, 8'h01, 2'b11); en[45] = 1'b0;
    scan(e);
    check_cpu("R3 cpu0", 0, 5, 1, 0);
    check_cpu("R3 cpu1", 1, 40, 1, 0);
  endtask

  task automatic t_tie();
    int e;
    clear_all();
    set_irq(60, 1, 8'h10, 2'b11);
    set_irq(35, 1, 8'h10, 2'b11);
    set_irq(33, 1, 8'h11, 2'b11);
    set_irq(62, 1, 8'h08, 2'b01);
    scan(e);
    check_cpu("R4 cpu0", 0, 62, 1, 0);
    check_cpu("R4 tie cpu1", 1, 35, 1, 0);
  endtask

  task automatic t_mask();
    int e;
    clear_all();
    set_irq(34, 1, 8'h80, 2'b11);
    pmask = {8'h81, 8'h80};
    scan(e);
    check_cpu("R7 equal mask", 0, 1023, 0, 0);
    check_cpu("R7 above mask", 1, 34, 1, 0);
  endtask

  task automatic t_running();
    int e;
    clear_all();
    set_irq(34, 1, 8'h40, 2'b11);
    rprio = {9'h041, 9'h040};
    scan(e);
    check_cpu("R8 equal running", 0, 34, 0, 0);
    check_cpu("R8 below running", 1, 34, 1, 0);
  endtask

  task automatic t_groups();
    int e;
    clear_all();
    set_irq(34, 0, 8'h10, 2'b11);
    dctl = 2'b10;
    scan(e);
    check_cpu("R9 dist grp0 off", 0, 34, 0, 0);
    dctl = 2'b11; cctl = {3'b001, 3'b010};
    scan(e);
    check_cpu("R9 cpu grp0 off", 0, 34, 0, 0);
    check_cpu("R9 grp0 on", 1, 34, 1, 0);
    dctl = 2'b00; cctl = {3'b011, 3'b011};
    scan(e);
    check_cpu("R6 dist off", 0, 1023, 0, 0);
    check_cpu("R6 dist off", 1, 1023, 0, 0);
    dctl = 2'b11; cctl = {3'b011, 3'b100};
    scan(e);
    check_cpu("R6 cpu off", 0, 1023, 0, 0);
    check_cpu("R6 other cpu", 1, 34, 1, 0);
  endtask

  task automatic t_fiq();
    int e;
    clear_all();
    set_irq(34, 0, 8'h10, 2'b11);
    cctl = {3'b011, 3'b101};
    scan(e);
    check_cpu("R10 fiq", 0, 34, 0, 1);
    check_cpu("R10 irq no fiq_en", 1, 34, 1, 0);
    grp[34] = 1'b1; cctl = {3'b011, 3'b111};
    scan(e);
    check_cpu("R10 grp1 irq", 0, 34, 1, 0);
  endtask

  task automatic t_restart();
    int e;
    clear_all();
    set_irq(34, 1, 8'h10, 2'b11);
    scan(e);
    recompute = 1'b1;
    @(negedge clk);
    recompute = 1'b0;
    repeat (10) @(negedge clk);
    check_cpu("R11 mid scan", 0, 34, 1, 0);
    en[34] = 1'b0;
    set_irq(36, 1, 8'h20, 2'b11);
    scan(e);
    check("R2 restart length", e, NI + 1);
    check_cpu("R2 restart result", 0, 36, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    recompute = 1'b0;
    clear_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing_empty();
    t_eligibility();
    t_tie();
    t_mask();
    t_running();
    t_groups();
    t_fiq();
    t_restart();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule